// File: doc/BRIEF.md
# Disk Packet-DMA Channel Register Block

This block holds the per-channel control and status registers of a two-channel packet-DMA disk controller behind a 16-bit memory-mapped bus. Software programs a descriptor count, a 32-bit next-descriptor pointer and two FIFO thresholds per channel. It writes a control word to start the packet engine, to hold the engine in reset, or to mask the channel interrupt. Engine events are captured into a status word that clears when it is read. While the status word is nonzero and the mask bit is clear, the channel raises its interrupt line.

Start commands are honoured only after the global lock byte holds the key value 7. Each channel runs a four-state sequencer:
- `CH_IDLE`: waiting for a start command.
- `CH_LAUNCH`: one cycle, drives the start pulse.
- `CH_ACTIVE`: the engine is running.
- `CH_RESET`: the reset bit is set and the engine reset is held.

The sequencer moves between these states as follows:
- `CH_IDLE` goes to `CH_LAUNCH` on an accepted start.
- `CH_LAUNCH` goes to `CH_ACTIVE` after its single cycle, or returns to `CH_IDLE` if a sequence-done or parity event arrives in that cycle.
- `CH_ACTIVE` returns to `CH_IDLE` on a sequence-done or parity event.
- Any of `CH_IDLE`, `CH_LAUNCH` and `CH_ACTIVE` goes to `CH_RESET` on a control write with the reset bit set.
- `CH_RESET` returns to `CH_IDLE` on a control write with the reset bit clear.

Top module: `dskdma_regfile`

## Requirements
- R1: After `rst_n` is released, every register reads 0, and `irq`, `eng_start` and `eng_rst` are all 0.
- R2: Channel n occupies byte addresses 0x80 + n*0x20 onward. Its registers sit at these offsets: control 0x00, status 0x02, count 0x04, pointer low half 0x0C, pointer high half 0x0E, input threshold 0x14, output threshold 0x16. Count, pointer and thresholds read back what was written. Any other address reads 0. Read data appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read.
- R3: The control word keeps bit 8 (interrupt mask), bit 5 (engine reset) and bits 1:0 (transfer mode). Bit 7 is the start command and always reads 0. All other bits read 0.
- R4: A control write with bit 7 set and bit 5 clear, to a channel in `CH_IDLE` while the lock holds 7, raises `eng_start[n]` for exactly the one cycle after the write.
- R5: A start command is ignored while the lock byte holds any value other than 7.
- R6: A start command in `CH_ACTIVE` produces no pulse. A sequence-done or parity event ends `CH_ACTIVE`, after which a new start is accepted.
- R7: The sequence-done event sets status bit 6, the unexpected-interrupt event sets bit 4 and the parity event sets bit 0. The bits stay set until read.
- R8: A status read returns the captured bits and clears them. An event that arrives in the same cycle as the read is kept for the next read.
- R9: `irq[n]` is 1 exactly when channel n's status is nonzero and its mask bit is 0.
- R10: While bit 5 is set, `eng_rst[n]` is 1, status stays 0 and events are dropped. Clearing bit 5 returns the channel to `CH_IDLE`. Count, pointer and thresholds are not changed by the engine reset.
- R11: The lock byte at address 0xC7 takes `bus_wdata[7:0]` on a write and reads back in the low byte. It changes only when written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| ev_seq | input | 2 | Per-channel sequence-done event |
| ev_uirq | input | 2 | Per-channel unexpected-interrupt event |
| ev_perr | input | 2 | Per-channel bus parity event |
| eng_start | output | 2 | Per-channel one-cycle start pulse |
| eng_rst | output | 2 | Per-channel held engine reset |
| irq | output | 2 | Per-channel masked interrupt |

## Verification
The start path is tried with four patterns, and each separates a different gating term:
- a locked key of 5, which shows the key compare;
- the correct key while the channel is idle, which shows the pulse and its single-cycle width;
- a start while the channel is active, which shows the sequencer state;
- a start after a done or parity event, which shows the return to idle.

Status is exercised three ways. Single events, read alone, show the bit positions. A read that coincides with an event shows that the clear does not swallow new bits. Events applied during the held reset show that they are dropped, while the count, pointer and threshold registers survive the reset.

// File: rtl/dskdma_pkg.sv
package dskdma_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_CNT,
        SEL_PTR_LO,
        SEL_PTR_HI,
        SEL_FIFO_IN,
        SEL_FIFO_OUT
    } reg_sel_e;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_LAUNCH,
        CH_ACTIVE,
        CH_RESET
    } chan_state_e;

    // byte offsets inside a channel window
    localparam int OFS_CTRL     = 'h00;
    localparam int OFS_STAT     = 'h02;
    localparam int OFS_CNT      = 'h04;
    localparam int OFS_PTR_LO   = 'h0C;
    localparam int OFS_PTR_HI   = 'h0E;
    localparam int OFS_FIFO_IN  = 'h14;
    localparam int OFS_FIFO_OUT = 'h16;

    // control word bit positions
    localparam int CTL_MASK  = 8;
    localparam int CTL_GO    = 7;
    localparam int CTL_RST   = 5;
    localparam int MODE_W    = 2;

    // status word bit positions
    localparam int STA_SEQ   = 6;
    localparam int STA_UIRQ  = 4;
    localparam int STA_PERR  = 0;

endpackage

// File: rtl/dskdma_addr_dec.sv
module dskdma_addr_dec
    import dskdma_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_CH    = 2,
    parameter int CH_BASE   = 'h80,
    parameter int CH_STRIDE = 'h20,
    parameter int LOCK_ADDR = 'hC7
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] ch_hit,
    output reg_sel_e          sel,
    output logic              lock_hit
);
    localparam int OFF_W = $clog2(CH_STRIDE);

    logic [OFF_W-1:0] off;
    assign off = addr[OFF_W-1:0];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
        localparam int LO = CH_BASE + g * CH_STRIDE;
        assign ch_hit[g] = (int'(addr) >= LO) && (int'(addr) < LO + CH_STRIDE);
    end

    always_comb begin
        case (int'(off))
            OFS_CTRL:     sel = SEL_CTRL;
            OFS_STAT:     sel = SEL_STAT;
            OFS_CNT:      sel = SEL_CNT;
            OFS_PTR_LO:   sel = SEL_PTR_LO;
            OFS_PTR_HI:   sel = SEL_PTR_HI;
            OFS_FIFO_IN:  sel = SEL_FIFO_IN;
            OFS_FIFO_OUT: sel = SEL_FIFO_OUT;
            default:      sel = SEL_NONE;
        endcase
    end

    assign lock_hit = (addr == ADDR_W'(LOCK_ADDR));

endmodule

// File: rtl/dskdma_chan_fsm.sv
module dskdma_chan_fsm
    import dskdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rst_set,
    input  logic        rst_clr,
    input  logic        go_req,
    input  logic        done_evt,
    output chan_state_e state,
    output logic        eng_start,
    output logic        eng_rst
);
    chan_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            CH_IDLE: begin
                if (rst_set)     nxt = CH_RESET;
                else if (go_req) nxt = CH_LAUNCH;
            end
            CH_LAUNCH: begin
                if (rst_set)       nxt = CH_RESET;
                else if (done_evt) nxt = CH_IDLE;
                else               nxt = CH_ACTIVE;
            end
            CH_ACTIVE: begin
                if (rst_set)       nxt = CH_RESET;
                else if (done_evt) nxt = CH_IDLE;
            end
            CH_RESET: begin
                if (rst_clr) nxt = CH_IDLE;
            end
        endcase
    end

    always_comb begin
        eng_start = (state == CH_LAUNCH);
        eng_rst   = (state == CH_RESET);
    end

endmodule

// File: rtl/dskdma_chan.sv
module dskdma_chan
    import dskdma_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              lock_ok,
    input  logic              ev_seq,
    input  logic              ev_uirq,
    input  logic              ev_perr,
    output logic [DATA_W-1:0] rd_val,
    output logic              eng_start,
    output logic              eng_rst,
    output logic              irq
);
    localparam int PTR_W = 2 * DATA_W;

    logic              mask_q, rstbit_q;
    logic [MODE_W-1:0] mode_q;
    logic              st_seq_q, st_uirq_q, st_perr_q;
    logic [DATA_W-1:0] cnt_q, fin_q, fout_q;
    logic [PTR_W-1:0]  ptr_q;
    chan_state_e       state;

    logic ctrl_wr, stat_rd, rst_set, rst_clr, go_req, wipe;
    assign ctrl_wr = wr && (sel == SEL_CTRL);
    assign stat_rd = rd && (sel == SEL_STAT);
    assign rst_set = ctrl_wr && wdata[CTL_RST];
    assign rst_clr = ctrl_wr && !wdata[CTL_RST];
    assign go_req  = ctrl_wr && wdata[CTL_GO] && lock_ok;

    dskdma_chan_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_set  (rst_set),
        .rst_clr  (rst_clr),
        .go_req   (go_req),
        .done_evt (ev_seq | ev_perr),
        .state    (state),
        .eng_start(eng_start),
        .eng_rst  (eng_rst)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= 1'b0;
            rstbit_q <= 1'b0;
            mode_q   <= '0;
            cnt_q    <= '0;
            ptr_q    <= '0;
            fin_q    <= '0;
            fout_q   <= '0;
        end else if (wr) begin
            case (sel)
                SEL_CTRL: begin
                    mask_q   <= wdata[CTL_MASK];
                    rstbit_q <= wdata[CTL_RST];
                    mode_q   <= wdata[MODE_W-1:0];
                end
                SEL_CNT:      cnt_q  <= wdata;
                SEL_PTR_LO:   ptr_q[DATA_W-1:0]     <= wdata;
                SEL_PTR_HI:   ptr_q[PTR_W-1:DATA_W] <= wdata;
                SEL_FIFO_IN:  fin_q  <= wdata;
                SEL_FIFO_OUT: fout_q <= wdata;
                default: ;
            endcase
        end
    end

    // status: cleared by engine reset, cleared by read, new events always kept
    assign wipe = (state == CH_RESET) || rst_set;

    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            st_seq_q  <= 1'b0;
            st_uirq_q <= 1'b0;
            st_perr_q <= 1'b0;
        end else begin
            st_seq_q  <= (st_seq_q  && !stat_rd) || ev_seq;
            st_uirq_q <= (st_uirq_q && !stat_rd) || ev_uirq;
            st_perr_q <= (st_perr_q && !stat_rd) || ev_perr;
        end
    end

    always_comb begin
        rd_val = '0;
        case (sel)
            SEL_CTRL: begin
                rd_val[CTL_MASK]     = mask_q;
                rd_val[CTL_RST]      = rstbit_q;
                rd_val[MODE_W-1:0]   = mode_q;
            end
            SEL_STAT: begin
                rd_val[STA_SEQ]  = st_seq_q;
                rd_val[STA_UIRQ] = st_uirq_q;
                rd_val[STA_PERR] = st_perr_q;
            end
            SEL_CNT:      rd_val = cnt_q;
            SEL_PTR_LO:   rd_val = ptr_q[DATA_W-1:0];
            SEL_PTR_HI:   rd_val = ptr_q[PTR_W-1:DATA_W];
            SEL_FIFO_IN:  rd_val = fin_q;
            SEL_FIFO_OUT: rd_val = fout_q;
            default:      rd_val = '0;
        endcase
    end

    assign irq = (st_seq_q || st_uirq_q || st_perr_q) && !mask_q;

endmodule

// File: rtl/dskdma_regfile.sv
module dskdma_regfile
    import dskdma_pkg::*;
#(
    parameter int NUM_CH    = 2,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int CH_BASE   = 'h80,
    parameter int CH_STRIDE = 'h20,
    parameter int LOCK_ADDR = 'hC7,
    parameter int LOCK_W    = 8,
    parameter int LOCK_KEY  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] ev_seq,
    input  logic [NUM_CH-1:0] ev_uirq,
    input  logic [NUM_CH-1:0] ev_perr,
    output logic [NUM_CH-1:0] eng_start,
    output logic [NUM_CH-1:0] eng_rst,
    output logic [NUM_CH-1:0] irq
);
    logic [NUM_CH-1:0] ch_hit;
    reg_sel_e          sel;
    logic              lock_hit;
    logic [LOCK_W-1:0] lock_q;
    logic              lock_ok;
    logic [DATA_W-1:0] ch_val [NUM_CH];
    logic [DATA_W-1:0] rd_mux;

    dskdma_addr_dec #(
        .ADDR_W   (ADDR_W),
        .NUM_CH   (NUM_CH),
        .CH_BASE  (CH_BASE),
        .CH_STRIDE(CH_STRIDE),
        .LOCK_ADDR(LOCK_ADDR)
    ) u_dec (
        .addr    (bus_addr),
        .ch_hit  (ch_hit),
        .sel     (sel),
        .lock_hit(lock_hit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                  lock_q <= '0;
        else if (bus_wr && lock_hit) lock_q <= bus_wdata[LOCK_W-1:0];
    end
    assign lock_ok = (lock_q == LOCK_W'(LOCK_KEY));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dskdma_chan #(.DATA_W(DATA_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (bus_wr && ch_hit[g]),
            .rd       (bus_rd && ch_hit[g]),
            .sel      (sel),
            .wdata    (bus_wdata),
            .lock_ok  (lock_ok),
            .ev_seq   (ev_seq[g]),
            .ev_uirq  (ev_uirq[g]),
            .ev_perr  (ev_perr[g]),
            .rd_val   (ch_val[g]),
            .eng_start(eng_start[g]),
            .eng_rst  (eng_rst[g]),
            .irq      (irq[g])
        );
    end

    always_comb begin
        rd_mux = lock_hit ? DATA_W'(lock_q) : '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_hit[i]) rd_mux = rd_mux | ch_val[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/dskdma_regfile_chk.sv
module dskdma_regfile_chk #(
    parameter int NUM_CH    = 2,
    parameter int ADDR_W    = 8,
    parameter int LOCK_ADDR = 'hC7,
    parameter int LOCK_W    = 8,
    parameter int LOCK_KEY  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NUM_CH-1:0] eng_start,
    input logic [NUM_CH-1:0] eng_rst,
    input logic [NUM_CH-1:0] irq,
    input logic [LOCK_W-1:0] lock_q
);
    // R4
    start_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start != '0) |=> ((eng_start & $past(eng_start)) == '0));

    // R4
    start_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start != '0) |-> $past(bus_wr));

    // R5
    start_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start != '0) |-> ($past(lock_q) == LOCK_W'(LOCK_KEY)));

    // R10
    reset_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rst & eng_start) == '0);

    // R10
    reset_silences_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rst & irq) == '0);

    // R11
    lock_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_W'(LOCK_ADDR)) |=> $stable(lock_q));

endmodule

bind dskdma_regfile dskdma_regfile_chk #(
    .NUM_CH   (NUM_CH),
    .ADDR_W   (ADDR_W),
    .LOCK_ADDR(LOCK_ADDR),
    .LOCK_W   (LOCK_W),
    .LOCK_KEY (LOCK_KEY)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .eng_start(eng_start),
    .eng_rst  (eng_rst),
    .irq      (irq),
    .lock_q   (lock_q)
);

// File: tb/dskdma_regfile_tb.sv
module dskdma_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  ev_seq = '0, ev_uirq = '0, ev_perr = '0;
    logic [1:0]  eng_start, eng_rst, irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dskdma_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_seq(ev_seq), .ev_uirq(ev_uirq), .ev_perr(ev_perr),
        .eng_start(eng_start), .eng_rst(eng_rst), .irq(irq)
    );

    // {is_read, requirement, address, data}
    localparam int NV = 27;
    localparam logic [28:0] VEC [NV] = '{
        {1'b0, 4'd2,  8'h84, 16'h1234},  // R2 count ch0
        {1'b0, 4'd2,  8'h8C, 16'hBEEF},  // R2 pointer low ch0
        {1'b0, 4'd2,  8'h8E, 16'hDEAD},  // R2 pointer high ch0
        {1'b0, 4'd2,  8'h94, 16'h0100},  // R2 input threshold ch0
        {1'b0, 4'd2,  8'h96, 16'h0180},  // R2 output threshold ch0
        {1'b0, 4'd2,  8'hA4, 16'h0001},  // R2 count ch1
        {1'b0, 4'd2,  8'hAC, 16'h5678},  // R2 pointer low ch1
        {1'b0, 4'd2,  8'hB6, 16'h00F0},  // R2 output threshold ch1
        {1'b1, 4'd2,  8'h84, 16'h1234},
        {1'b1, 4'd2,  8'h8C, 16'hBEEF},
        {1'b1, 4'd2,  8'h8E, 16'hDEAD},
        {1'b1, 4'd2,  8'h94, 16'h0100},
        {1'b1, 4'd2,  8'h96, 16'h0180},
        {1'b1, 4'd2,  8'hA4, 16'h0001},
        {1'b1, 4'd2,  8'hAC, 16'h5678},
        {1'b1, 4'd2,  8'hB6, 16'h00F0},
        {1'b1, 4'd2,  8'hA0, 16'h0000},  // R2 ch1 control untouched
        {1'b0, 4'd3,  8'h80, 16'h0103},  // R3 mask + mode
        {1'b1, 4'd3,  8'h80, 16'h0103},
        {1'b0, 4'd3,  8'h80, 16'hFFDF},  // R3 all but reset bit
        {1'b1, 4'd3,  8'h80, 16'h0103},
        {1'b0, 4'd3,  8'h80, 16'h0003},
        {1'b1, 4'd2,  8'h90, 16'h0000},  // R2 hole in window
        {1'b1, 4'd2,  8'h98, 16'h0000},  // R2 hole in window
        {1'b1, 4'd2,  8'hC0, 16'h0000},  // R2 outside channels
        {1'b0, 4'd11, 8'hC7, 16'h0005},  // R11 wrong key
        {1'b1, 4'd11, 8'hC7, 16'h0005}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse_ev(input int kind, input int ch);
        @(negedge clk);
        case (kind)
            0: ev_seq[ch]  = 1'b1;
            1: ev_uirq[ch] = 1'b1;
            default: ev_perr[ch] = 1'b1;
        endcase
        @(negedge clk);
        ev_seq = '0; ev_uirq = '0; ev_perr = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 eng_start", 32'(eng_start), 0);
        chk("R1 eng_rst", 32'(eng_rst), 0);
        rd(8'h80, v); chk("R1 ctrl0", 32'(v), 0);
        rd(8'h82, v); chk("R1 stat0", 32'(v), 0);
        rd(8'hA4, v); chk("R1 count1", 32'(v), 0);
        rd(8'hC7, v); chk("R1 lock", 32'(v), 0);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k][28]) begin
                rd(VEC[k][23:16], v);
                chk($sformatf("R%0d table %0d", VEC[k][27:24], k), 32'(v), 32'(VEC[k][15:0]));
            end else begin
                wr(VEC[k][23:16], VEC[k][15:0]);
            end
        end

        // R5 wrong key: no pulse
        wr(8'h80, 16'h0083);
        chk("R5 no start", 32'(eng_start), 0);
        @(negedge clk); chk("R5 no start late", 32'(eng_start), 0);

        // R4 correct key
        wr(8'hC7, 16'h0007);
        wr(8'h80, 16'h0083);
        chk("R4 pulse", 32'(eng_start), 32'h1);
        @(negedge clk); chk("R4 pulse width", 32'(eng_start), 0);
        rd(8'h80, v); chk("R3 go reads 0", 32'(v), 32'h0003);

        // R6 start while active ignored
        wr(8'h80, 16'h0083);
        chk("R6 busy no start", 32'(eng_start), 0);
        pulse_ev(0, 0);
        chk("R9 irq on seq", 32'(irq), 32'h1);
        wr(8'h80, 16'h0083);
        chk("R6 restart after done", 32'(eng_start), 32'h1);

        // R7 / R8 capture and clear
        pulse_ev(1, 0);
        rd(8'h82, v); chk("R7 seq+uirq bits", 32'(v), 32'h0050);
        chk("R8 irq after clear", 32'(irq), 0);
        rd(8'h82, v); chk("R8 cleared", 32'(v), 0);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 8'h82; ev_perr[0] = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; ev_perr = '0;
        chk("R8 read before event", 32'(bus_rdata), 0);
        rd(8'h82, v); chk("R8 same-cycle event kept", 32'(v), 32'h0001);

        // R9 mask
        pulse_ev(1, 0);
        chk("R9 irq unmasked", 32'(irq), 32'h1);
        wr(8'h80, 16'h0103);
        chk("R9 irq masked", 32'(irq), 0);
        wr(8'h80, 16'h0003);
        chk("R9 irq unmask again", 32'(irq), 32'h1);
        rd(8'h82, v); chk("R7 uirq bit", 32'(v), 32'h0010);

        // R10 engine reset
        wr(8'h80, 16'h0083);
        chk("R10 start before reset", 32'(eng_start), 32'h1);
        pulse_ev(1, 0);
        wr(8'h80, 16'h0023);
        chk("R10 eng_rst held", 32'(eng_rst), 32'h1);
        chk("R10 irq cleared", 32'(irq), 0);
        pulse_ev(0, 0);
        chk("R10 event dropped irq", 32'(irq), 0);
        rd(8'h82, v); chk("R10 status zero", 32'(v), 0);
        chk("R10 still held", 32'(eng_rst), 32'h1);
        wr(8'h80, 16'h0003);
        chk("R10 released", 32'(eng_rst), 0);
        rd(8'h84, v); chk("R10 count kept", 32'(v), 32'h1234);
        rd(8'h8C, v); chk("R10 pointer kept", 32'(v), 32'hBEEF);
        rd(8'h94, v); chk("R10 threshold kept", 32'(v), 32'h0100);
        wr(8'h80, 16'h0083);
        chk("R10 idle after release", 32'(eng_start), 32'h1);

        // channel 1 independence
        wr(8'hA0, 16'h0083);
        chk("R4 ch1 pulse", 32'(eng_start), 32'h2);
        pulse_ev(2, 1);
        chk("R9 ch1 irq", 32'(irq), 32'h2);
        rd(8'hA2, v); chk("R7 ch1 perr", 32'(v), 32'h0001);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule